// File: doc/BRIEF.md
# Operand Bypass Controller

This block decides, every cycle, where the operands of a five-stage load/store pipeline come from when a recent instruction has produced a result that is not yet in the register file. It compares the two source register indices of the instruction in the execute stage with the destination indices and write enables of the two older instructions still in flight. The older ones are the one leaving execute, held in the execute/memory register, and the one in the memory/writeback register. For each ALU input it emits a two-bit select code and drives the chosen value.

A second, narrower path serves branches that are resolved in decode. When the decoded instruction is a branch, each input of the decode-stage equality comparator can take the result held in the execute/memory register instead of the register-file read. The whole block is combinational. The register file, ALU and pipeline registers sit outside it.

Top module: `operand_bypass`

## Requirements
- R1: When `memWrEn` is 1, `memDstIdx` is nonzero and equals `exRsIdx`, `aluSelA` is binary 10 and `aluOpA` equals `memResult`.
- R2: When `memWrEn` is 1, `memDstIdx` is nonzero and equals `exRtIdx`, `aluSelB` is binary 10 and `aluOpB` equals `memResult`.
- R3: When `wbWrEn` is 1, `wbDstIdx` is nonzero and equals an execute-stage source, and the R1/R2 condition does not hold for that operand, that operand's select is binary 01 and its value equals `wbResult`.
- R4: When both older stages qualify for the same operand, the execute/memory result wins (code 10). This keeps the most recent producer in a run of back-to-back writes to one register.
- R5: With no qualifying match, the select is binary 00 and the operand equals the execute-stage register value (`exRsVal` / `exRtVal`). Code 11 never appears.
- R6: Register index 0 is never forwarded, whatever the write enables and destinations.
- R7: Each operand output always equals the source named by its select code: 10 gives `memResult`, 01 gives `wbResult`, 00 gives the execute-stage value.
- R8: When `idIsBranch` is 1, `memDstIdx` is nonzero and equals `idRsIdx` (or `idRtIdx`), `cmpSelA` (or `cmpSelB`) is 1 and `cmpOpA` (or `cmpOpB`) equals `memResult`.
- R9: With `idIsBranch` at 0, or with only the memory/writeback destination matching, the comparator selects are 0 and the comparator operands equal `idRsVal` / `idRtVal`. The register file's write-first behaviour already covers older results.
- R10: The two operands are decided independently, so each may forward from a different stage, or both from the same one, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRsIdx | input | REG_W | First source index of the execute-stage instruction |
| exRtIdx | input | REG_W | Second source index of the execute-stage instruction |
| exRsVal | input | DATA_W | First operand value read into the execute stage |
| exRtVal | input | DATA_W | Second operand value read into the execute stage |
| memWrEn | input | 1 | Register write enable in the execute/memory register |
| memDstIdx | input | REG_W | Destination index in the execute/memory register |
| memResult | input | DATA_W | Result held in the execute/memory register |
| wbWrEn | input | 1 | Register write enable in the memory/writeback register |
| wbDstIdx | input | REG_W | Destination index in the memory/writeback register |
| wbResult | input | DATA_W | Write-back value of the memory/writeback register |
| idIsBranch | input | 1 | Decoded instruction is a decode-resolved branch |
| idRsIdx | input | REG_W | First source index of the decoded instruction |
| idRtIdx | input | REG_W | Second source index of the decoded instruction |
| idRsVal | input | DATA_W | Register-file read of the first decode source |
| idRtVal | input | DATA_W | Register-file read of the second decode source |
| aluSelA | output | 2 | Select code for ALU input A (00 / 01 / 10) |
| aluSelB | output | 2 | Select code for ALU input B (00 / 01 / 10) |
| cmpSelA | output | 1 | Comparator input A takes the execute/memory result |
| cmpSelB | output | 1 | Comparator input B takes the execute/memory result |
| aluOpA | output | DATA_W | Selected ALU operand A |
| aluOpB | output | DATA_W | Selected ALU operand B |
| cmpOpA | output | DATA_W | Selected comparator operand A |
| cmpOpB | output | DATA_W | Selected comparator operand B |

## Verification
The in-RTL checks hold continuously for any input. No select ever points at register 0. Code 11 never appears. A writeback selection never coexists with a qualifying execute/memory match. Comparator selects appear only for branches. Every operand value agrees with its select code. Whether the right producer is chosen for concrete sequences can only be shown by the bench's scenarios. These include three back-to-back writes to one register, both operands hitting at once, a disabled nearer writer that must fall through to the older one, and a decode branch that must ignore the writeback stage.

// File: rtl/bypass_pkg.sv
`timescale 1ns/1ps
package bypass_pkg;

  // Operand source codes; the code values are decoded by the operand mux.
  typedef enum logic [1:0] {
    SRC_REGREAD = 2'b00,
    SRC_WBSTAGE = 2'b01,
    SRC_MEMSTAGE = 2'b10
  } opSrc_e;

  localparam int NUM_ALU_OPS = 2;
  localparam int NUM_CMP_OPS = 2;

  // Strobes from the control to the datapath.
  typedef struct packed {
    opSrc_e [NUM_ALU_OPS-1:0] aluSrc;
    logic   [NUM_CMP_OPS-1:0] cmpTakeMem;
  } bypassStrobes_t;

endpackage

// File: rtl/bypass_ctrl.sv
`timescale 1ns/1ps
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_ALU_OPS-1:0][REG_W-1:0] exSrcIdx,
  input  logic                              memWrEn,
  input  logic [REG_W-1:0]                  memDstIdx,
  input  logic                              wbWrEn,
  input  logic [REG_W-1:0]                  wbDstIdx,
  input  logic                              idIsBranch,
  input  logic [NUM_CMP_OPS-1:0][REG_W-1:0] idSrcIdx,
  output bypassStrobes_t                    strobes
);

  // A writer qualifies only if it writes a register other than index 0.
  logic memLive;
  logic wbLive;
  assign memLive = memWrEn && (memDstIdx != '0);
  assign wbLive  = wbWrEn  && (wbDstIdx  != '0);

  for (genvar g = 0; g < NUM_ALU_OPS; g++) begin : g_alu
    logic memHit;
    logic wbHit;
    assign memHit = memLive && (memDstIdx == exSrcIdx[g]);
    assign wbHit  = wbLive  && (wbDstIdx  == exSrcIdx[g]);

    // Priority: nearer producer first, then older, then register read.
    always_comb begin
      if (memHit)      strobes.aluSrc[g] = SRC_MEMSTAGE;
      else if (wbHit)  strobes.aluSrc[g] = SRC_WBSTAGE;
      else             strobes.aluSrc[g] = SRC_REGREAD;
    end

    always_comb begin
      // R6: a forwarding select implies a nonzero source index
      p_no_zero_fwd_r6: assert (strobes.aluSrc[g] == SRC_REGREAD || exSrcIdx[g] != '0);
      // R5: the unused code never leaves the control
      p_legal_code_r5: assert (strobes.aluSrc[g] != opSrc_e'(2'b11));
      // R4: writeback selection only when the nearer stage is not writing this register
      p_wb_yields_r4: assert (strobes.aluSrc[g] != SRC_WBSTAGE
                              || !memWrEn || memDstIdx != exSrcIdx[g] || memDstIdx == '0);
      // R3: writeback selection needs an enabled writeback writer
      p_wb_needs_en_r3: assert (strobes.aluSrc[g] != SRC_WBSTAGE || wbWrEn);
    end
  end

  // Decode-stage comparator: only the execute/memory result is bypassed.
  // Older results reach the register file write-first in the same cycle.
  for (genvar c = 0; c < NUM_CMP_OPS; c++) begin : g_cmp
    assign strobes.cmpTakeMem[c] = idIsBranch && (memDstIdx != '0)
                                   && (memDstIdx == idSrcIdx[c]);

    always_comb begin
      // R9: comparator bypass only for branches
      p_cmp_branch_only_r9: assert (!strobes.cmpTakeMem[c] || idIsBranch);
      // R6: comparator never bypasses register 0
      p_cmp_no_zero_r6: assert (!strobes.cmpTakeMem[c] || idSrcIdx[c] != '0);
    end
  end

endmodule

// File: rtl/bypass_data.sv
`timescale 1ns/1ps
module bypass_data
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  bypassStrobes_t                     strobes,
  input  logic [NUM_ALU_OPS-1:0][DATA_W-1:0] exVal,
  input  logic [DATA_W-1:0]                  memResult,
  input  logic [DATA_W-1:0]                  wbResult,
  input  logic [NUM_CMP_OPS-1:0][DATA_W-1:0] idVal,
  output logic [NUM_ALU_OPS-1:0][DATA_W-1:0] aluOp,
  output logic [NUM_CMP_OPS-1:0][DATA_W-1:0] cmpOp
);

  for (genvar g = 0; g < NUM_ALU_OPS; g++) begin : g_aluMux
    always_comb begin
      unique case (strobes.aluSrc[g])
        SRC_MEMSTAGE: aluOp[g] = memResult;
        SRC_WBSTAGE:  aluOp[g] = wbResult;
        default:      aluOp[g] = exVal[g];
      endcase
    end

    always_comb begin
      // R7: operand agrees with the code handed over by the control
      p_alu_mux_r7: assert ((strobes.aluSrc[g] == SRC_MEMSTAGE && aluOp[g] == memResult)
                         || (strobes.aluSrc[g] == SRC_WBSTAGE  && aluOp[g] == wbResult)
                         || (strobes.aluSrc[g] == SRC_REGREAD  && aluOp[g] == exVal[g])
                         || (strobes.aluSrc[g] == opSrc_e'(2'b11)));
    end
  end

  for (genvar c = 0; c < NUM_CMP_OPS; c++) begin : g_cmpMux
    assign cmpOp[c] = strobes.cmpTakeMem[c] ? memResult : idVal[c];

    always_comb begin
      // R8: comparator operand follows its strobe
      p_cmp_mux_r8: assert (strobes.cmpTakeMem[c] ? (cmpOp[c] == memResult)
                                                  : (cmpOp[c] == idVal[c]));
    end
  end

endmodule

// File: rtl/operand_bypass.sv
`timescale 1ns/1ps
module operand_bypass
  import bypass_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  exRsIdx,
  input  logic [REG_W-1:0]  exRtIdx,
  input  logic [DATA_W-1:0] exRsVal,
  input  logic [DATA_W-1:0] exRtVal,
  input  logic              memWrEn,
  input  logic [REG_W-1:0]  memDstIdx,
  input  logic [DATA_W-1:0] memResult,
  input  logic              wbWrEn,
  input  logic [REG_W-1:0]  wbDstIdx,
  input  logic [DATA_W-1:0] wbResult,
  input  logic              idIsBranch,
  input  logic [REG_W-1:0]  idRsIdx,
  input  logic [REG_W-1:0]  idRtIdx,
  input  logic [DATA_W-1:0] idRsVal,
  input  logic [DATA_W-1:0] idRtVal,
  output logic [1:0]        aluSelA,
  output logic [1:0]        aluSelB,
  output logic              cmpSelA,
  output logic              cmpSelB,
  output logic [DATA_W-1:0] aluOpA,
  output logic [DATA_W-1:0] aluOpB,
  output logic [DATA_W-1:0] cmpOpA,
  output logic [DATA_W-1:0] cmpOpB
);

  bypassStrobes_t                     strobes;
  logic [NUM_ALU_OPS-1:0][DATA_W-1:0] aluOp;
  logic [NUM_CMP_OPS-1:0][DATA_W-1:0] cmpOp;

  bypass_ctrl #(.REG_W(REG_W)) u_ctrl (
    .exSrcIdx   ({exRtIdx, exRsIdx}),
    .memWrEn    (memWrEn),
    .memDstIdx  (memDstIdx),
    .wbWrEn     (wbWrEn),
    .wbDstIdx   (wbDstIdx),
    .idIsBranch (idIsBranch),
    .idSrcIdx   ({idRtIdx, idRsIdx}),
    .strobes    (strobes)
  );

  bypass_data #(.DATA_W(DATA_W)) u_data (
    .strobes   (strobes),
    .exVal     ({exRtVal, exRsVal}),
    .memResult (memResult),
    .wbResult  (wbResult),
    .idVal     ({idRtVal, idRsVal}),
    .aluOp     (aluOp),
    .cmpOp     (cmpOp)
  );

  assign aluSelA = strobes.aluSrc[0];
  assign aluSelB = strobes.aluSrc[1];
  assign cmpSelA = strobes.cmpTakeMem[0];
  assign cmpSelB = strobes.cmpTakeMem[1];
  assign aluOpA  = aluOp[0];
  assign aluOpB  = aluOp[1];
  assign cmpOpA  = cmpOp[0];
  assign cmpOpB  = cmpOp[1];

endmodule

// File: tb/sim_operand_bypass.sv
`timescale 1ns/1ps
module sim_operand_bypass;

  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] RS_V  = 32'h1111_0001;
  localparam logic [DATA_W-1:0] RT_V  = 32'h2222_0002;
  localparam logic [DATA_W-1:0] MEM_V = 32'h3333_0003;
  localparam logic [DATA_W-1:0] WB_V  = 32'h4444_0004;
  localparam logic [DATA_W-1:0] IDS_V = 32'h5555_0005;
  localparam logic [DATA_W-1:0] IDT_V = 32'h6666_0006;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [REG_W-1:0]  exRsIdx, exRtIdx, memDstIdx, wbDstIdx, idRsIdx, idRtIdx;
  logic [DATA_W-1:0] exRsVal, exRtVal, memResult, wbResult, idRsVal, idRtVal;
  logic              memWrEn, wbWrEn, idIsBranch;
  logic [1:0]        aluSelA, aluSelB;
  logic              cmpSelA, cmpSelB;
  logic [DATA_W-1:0] aluOpA, aluOpB, cmpOpA, cmpOpB;

  operand_bypass #(.REG_W(REG_W), .DATA_W(DATA_W)) u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Code 10 -> execute/memory result, 01 -> writeback, 00 -> register read (R7).
  function automatic logic [DATA_W-1:0] pick(input logic [1:0] code,
                                             input logic [DATA_W-1:0] own);
    case (code)
      2'b10:   return MEM_V;
      2'b01:   return WB_V;
      default: return own;
    endcase
  endfunction

  typedef struct packed {
    logic [4:0] rs;
    logic [4:0] rt;
    logic       mw;
    logic [4:0] md;
    logic       ww;
    logic [4:0] wd;
    logic [1:0] ea;
    logic [1:0] eb;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{5'd1,  5'd2,  1'b1, 5'd1,  1'b0, 5'd0,  2'b10, 2'b00, 4'd1},  // R1
    '{5'd1,  5'd2,  1'b1, 5'd2,  1'b0, 5'd0,  2'b00, 2'b10, 4'd2},  // R2
    '{5'd1,  5'd2,  1'b0, 5'd1,  1'b1, 5'd1,  2'b01, 2'b00, 4'd3},  // R3 nearer writer disabled
    '{5'd3,  5'd4,  1'b1, 5'd5,  1'b1, 5'd4,  2'b00, 2'b01, 4'd3},  // R3
    '{5'd3,  5'd3,  1'b1, 5'd3,  1'b1, 5'd3,  2'b10, 2'b10, 4'd4},  // R4 back-to-back writes
    '{5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00, 4'd6},  // R6 register 0
    '{5'd7,  5'd8,  1'b1, 5'd7,  1'b1, 5'd8,  2'b10, 2'b01, 4'd10}, // R10 mixed stages
    '{5'd9,  5'd9,  1'b0, 5'd9,  1'b0, 5'd9,  2'b00, 2'b00, 4'd5},  // R5 writes disabled
    '{5'd31, 5'd30, 1'b1, 5'd30, 1'b1, 5'd31, 2'b01, 2'b10, 4'd10}, // R10 crossed
    '{5'd6,  5'd0,  1'b1, 5'd0,  1'b1, 5'd6,  2'b01, 2'b00, 4'd6}   // R6 zero dest, R3
  };

  task automatic idle();
    exRsIdx = '0; exRtIdx = '0; memDstIdx = '0; wbDstIdx = '0;
    idRsIdx = '0; idRtIdx = '0; memWrEn = 1'b0; wbWrEn = 1'b0; idIsBranch = 1'b0;
    exRsVal = RS_V; exRtVal = RT_V; memResult = MEM_V; wbResult = WB_V;
    idRsVal = IDS_V; idRtVal = IDT_V;
  endtask

  initial begin
    idle();
    @(negedge clk); #1;
    // Quiescent state (R5, R9)
    check("R5", "idle selA", {30'd0, aluSelA}, 32'd0);
    check("R5", "idle opB", aluOpB, RT_V);
    check("R9", "idle cmpA", {31'd0, cmpSelA}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      @(negedge clk);
      exRsIdx = VECS[i].rs; exRtIdx = VECS[i].rt;
      memWrEn = VECS[i].mw; memDstIdx = VECS[i].md;
      wbWrEn  = VECS[i].ww; wbDstIdx  = VECS[i].wd;
      #1;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      check(tag, "selA", {30'd0, aluSelA}, {30'd0, VECS[i].ea});
      check(tag, "selB", {30'd0, aluSelB}, {30'd0, VECS[i].eb});
      check(tag, "opA (R7)", aluOpA, pick(VECS[i].ea, RS_V));
      check(tag, "opB (R7)", aluOpB, pick(VECS[i].eb, RT_V));
    end

    // R8: branch sources match the execute/memory destination
    @(negedge clk); idle();
    idIsBranch = 1'b1; idRsIdx = 5'd4; idRtIdx = 5'd9; memDstIdx = 5'd4; memWrEn = 1'b1;
    #1;
    check("R8", "cmpSelA", {31'd0, cmpSelA}, 32'd1);
    check("R8", "cmpOpA", cmpOpA, MEM_V);
    check("R8", "cmpSelB", {31'd0, cmpSelB}, 32'd0);
    check("R8", "cmpOpB", cmpOpB, IDT_V);

    // R8 with R10: both comparator inputs hit
    @(negedge clk); idRtIdx = 5'd4; #1;
    check("R8", "both cmpOpA", cmpOpA, MEM_V);
    check("R8", "both cmpOpB", cmpOpB, MEM_V);

    // R9: not a branch -> no comparator bypass
    @(negedge clk); idIsBranch = 1'b0; #1;
    check("R9", "nonbranch cmpOpA", cmpOpA, IDS_V);
    check("R9", "nonbranch cmpSelB", {31'd0, cmpSelB}, 32'd0);

    // R9: only writeback matches -> register read
    @(negedge clk); idle();
    idIsBranch = 1'b1; idRsIdx = 5'd12; wbWrEn = 1'b1; wbDstIdx = 5'd12; memDstIdx = 5'd13;
    #1;
    check("R9", "wb-only cmpSelA", {31'd0, cmpSelA}, 32'd0);
    check("R9", "wb-only cmpOpA", cmpOpA, IDS_V);

    // R6: branch on register 0 with destination 0
    @(negedge clk); idle();
    idIsBranch = 1'b1; memWrEn = 1'b1; #1;
    check("R6", "zero cmpSelA", {31'd0, cmpSelA}, 32'd0);
    check("R6", "zero cmpOpB", cmpOpB, IDT_V);

    // R4: value check under same-register conflict with new data
    @(negedge clk); idle();
    exRsIdx = 5'd17; memWrEn = 1'b1; memDstIdx = 5'd17; wbWrEn = 1'b1; wbDstIdx = 5'd17;
    memResult = 32'hDEAD_BEEF; #1;
    check("R4", "priority opA", aluOpA, 32'hDEAD_BEEF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule